// File: doc/BRIEF.md
# Field Timing Sequence Selector

This block plays back a short programmed list of field-timing indices, one entry per vertical-sync period. Software loads the list with a single register write. That write carries a field count and up to seven 5-bit field selectors. The rest of the timing core reads the active field index and the current list position from this block, and uses them to pick which stored field description drives the present frame.

A mode write is held pending. It replaces the running list only on the next vertical-sync strobe, so a list never changes in the middle of a field. Each later strobe moves one step along the list. After the last used entry, the list wraps back to the first.

The register port is a plain strobe interface with no back-pressure: every write is accepted in the cycle its strobe is high. The vertical-sync input is a single-cycle strobe.

Top module: `fs_field_seq`

## Requirements
- R1: A write is taken as a mode write only when `reg_wr` is high and `reg_addr[11:10]` is `2'b10`. A write with any other value in those two bits changes neither the pending list nor the running list.
- R2: The mode word is 38 bits, formed as `{reg_addr[9:0], reg_wdata[27:0]}`. Bits 37:35 hold the field count. Selector k (k = 0..6) sits in bits 5k+4:5k, and selector 0 is played first.
- R3: A mode write does not change `field_sel` or `seq_pos` before the next `vd_pulse`.
- R4: On the first `vd_pulse` after a mode write, `seq_pos` becomes 0 and `field_sel` becomes selector 0 of the new word.
- R5: On each further `vd_pulse`, `seq_pos` rises by one and `field_sel` shows the selector at that position.
- R6: On a `vd_pulse` at position count-1, `seq_pos` wraps to 0 and `field_sel` returns to selector 0.
- R7: A field count of 0 behaves as a count of 1, so the block stays on selector 0.
- R8: After reset, `seq_pos` is 0, `field_sel` is 0, and no write is pending.
- R9: If several mode writes arrive before a `vd_pulse`, the last one is applied. A mode write in the same cycle as a `vd_pulse` is held for the following strobe, while the write pending before that cycle is applied now.
- R10: Without a `vd_pulse`, `field_sel` and `seq_pos` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register address; low 10 bits are data in a mode write |
| reg_wdata | input | 28 | Register write data |
| vd_pulse | input | 1 | Vertical-sync strobe, one cycle wide |
| field_sel | output | 5 | Active field index |
| seq_pos | output | 3 | Current position in the list |

## Verification
The checker tests several rules on every cycle. It confirms that the position stays below the effective count, and that the outputs hold between strobes. It confirms that a strobe with a pending word resets the position, that a plain strobe advances or wraps the position, and that a write with no strobe leaves the outputs alone. The bench scenarios are the only place where the bit layout is seen end to end. They show each selector emerging in the right order, an ignored address leaving the running list untouched, the last of several writes winning, and a write that coincides with a strobe being deferred by one field.

// File: rtl/fs_field_seq_pkg.sv
package fs_field_seq_pkg;
  localparam int unsigned ADDR_W  = 12;
  localparam int unsigned DATA_W  = 28;
  localparam int unsigned SEL_W   = 5;
  localparam int unsigned NUM_SEL = 7;
  localparam int unsigned CNT_W   = 3;
  localparam int unsigned WORD_W  = CNT_W + NUM_SEL * SEL_W;
  localparam int unsigned ADDR_AS_DATA = WORD_W - DATA_W;
  localparam logic [1:0]  MODE_TAG = 2'b10;
endpackage

// File: rtl/fs_write_decode.sv
module fs_write_decode
  import fs_field_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              vd_pulse,
  output logic              pend_vld,
  output logic [WORD_W-1:0] pend_word
);
  logic              is_mode;
  logic [WORD_W-1:0] word_in;

  // R1 address tag, R2 word assembly
  assign is_mode = reg_wr && (reg_addr[ADDR_W-1 -: 2] == MODE_TAG);
  assign word_in = {reg_addr[ADDR_AS_DATA-1:0], reg_wdata};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld  <= 1'b0;
      pend_word <= '0;
    end else if (is_mode) begin
      // R9: newest write wins; a write on a strobe cycle waits for the next strobe
      pend_vld  <= 1'b1;
      pend_word <= word_in;
    end else if (vd_pulse) begin
      pend_vld  <= 1'b0;
    end
  end
endmodule

// File: rtl/fs_seq_step.sv
module fs_seq_step
  import fs_field_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vd_pulse,
  input  logic              pend_vld,
  input  logic [WORD_W-1:0] pend_word,
  output logic [WORD_W-1:0] act_word,
  output logic [CNT_W-1:0]  act_cnt,
  output logic [CNT_W-1:0]  pos
);
  logic [CNT_W-1:0] cnt_eff;
  logic             at_last;

  assign act_cnt = act_word[WORD_W-1 -: CNT_W];
  assign cnt_eff = (act_cnt == '0) ? CNT_W'(1) : act_cnt;   // R7
  assign at_last = (pos >= cnt_eff - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_word <= '0;
      pos      <= '0;
    end else if (vd_pulse) begin
      if (pend_vld) begin
        act_word <= pend_word;      // R4
        pos      <= '0;
      end else if (at_last) begin
        pos      <= '0;             // R6
      end else begin
        pos      <= pos + CNT_W'(1); // R5
      end
    end
  end
endmodule

// File: rtl/fs_sel_mux.sv
module fs_sel_mux
  import fs_field_seq_pkg::*;
(
  input  logic [WORD_W-1:0] act_word,
  input  logic [CNT_W-1:0]  pos,
  output logic [SEL_W-1:0]  sel
);
  logic [SEL_W-1:0] slot [NUM_SEL];

  for (genvar k = 0; k < NUM_SEL; k++) begin : g_slot
    assign slot[k] = act_word[k*SEL_W +: SEL_W];
  end

  always_comb begin
    sel = '0;
    for (int k = 0; k < NUM_SEL; k++) begin
      if (pos == CNT_W'(k)) sel = slot[k];
    end
  end
endmodule

// File: rtl/fs_field_seq.sv
module fs_field_seq
  import fs_field_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              vd_pulse,
  output logic [SEL_W-1:0]  field_sel,
  output logic [CNT_W-1:0]  seq_pos
);
  logic              pend_vld;
  logic [WORD_W-1:0] pend_word;
  logic [WORD_W-1:0] act_word;
  logic [CNT_W-1:0]  act_cnt;

  fs_write_decode u_dec (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .vd_pulse(vd_pulse),
    .pend_vld(pend_vld), .pend_word(pend_word)
  );

  fs_seq_step u_step (
    .clk(clk), .rst_n(rst_n), .vd_pulse(vd_pulse),
    .pend_vld(pend_vld), .pend_word(pend_word),
    .act_word(act_word), .act_cnt(act_cnt), .pos(seq_pos)
  );

  fs_sel_mux u_mux (
    .act_word(act_word), .pos(seq_pos), .sel(field_sel)
  );
endmodule

// File: rtl/fs_field_seq_chk.sv
module fs_field_seq_chk
  import fs_field_seq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              vd_pulse,
  input logic              pend_vld,
  input logic [CNT_W-1:0]  act_cnt,
  input logic [CNT_W-1:0]  seq_pos,
  input logic [SEL_W-1:0]  field_sel
);
  logic [CNT_W-1:0] cnt_eff;
  assign cnt_eff = (act_cnt == '0) ? CNT_W'(1) : act_cnt;

  a_r7_pos_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    seq_pos < cnt_eff);

  a_r10_hold_no_vd: assert property (@(posedge clk) disable iff (!rst_n)
    !vd_pulse |=> ($stable(seq_pos) && $stable(field_sel)));

  a_r4_apply_resets_pos: assert property (@(posedge clk) disable iff (!rst_n)
    (vd_pulse && pend_vld) |=> (seq_pos == '0));

  a_r5_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (vd_pulse && !pend_vld && (seq_pos + CNT_W'(1) < cnt_eff))
      |=> (seq_pos == $past(seq_pos) + CNT_W'(1)));

  a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (vd_pulse && !pend_vld && (seq_pos + CNT_W'(1) >= cnt_eff))
      |=> (seq_pos == '0));

  a_r3_write_deferred: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !vd_pulse) |=> $stable(field_sel));
endmodule

bind fs_field_seq fs_field_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .vd_pulse(vd_pulse),
  .pend_vld(pend_vld), .act_cnt(act_cnt), .seq_pos(seq_pos),
  .field_sel(field_sel)
);

// File: tb/fs_field_seq_tb.sv
module fs_field_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [27:0] reg_wdata = '0;
  logic        vd_pulse = 1'b0;
  logic [4:0]  field_sel;
  logic [2:0]  seq_pos;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fs_field_seq dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .vd_pulse(vd_pulse),
    .field_sel(field_sel), .seq_pos(seq_pos)
  );

  function automatic logic [37:0] mk_word(input logic [2:0] cnt,
      input logic [4:0] s0, s1, s2, s3, s4, s5, s6);
    return {cnt, s6, s5, s4, s3, s2, s1, s0};
  endfunction

  task automatic check(input string req, input logic [4:0] exp_sel, input logic [2:0] exp_pos);
    checks++;
    if (field_sel !== exp_sel || seq_pos !== exp_pos) begin
      errors++;
      $display("FAIL %s: field_sel=%0d seq_pos=%0d expected field_sel=%0d seq_pos=%0d",
               req, field_sel, seq_pos, exp_sel, exp_pos);
    end
  endtask

  // drive on falling edge; tag is reg_addr[11:10]
  task automatic put_write(input logic [1:0] tag, input logic [37:0] w, input bit with_vd);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = {tag, w[37:28]}; reg_wdata = w[27:0];
    vd_pulse = with_vd;
    @(negedge clk);
    reg_wr = 1'b0; vd_pulse = 1'b0;
  endtask

  task automatic pulse_vd();
    @(negedge clk); vd_pulse = 1'b1;
    @(negedge clk); vd_pulse = 1'b0;
  endtask

  task automatic t_reset();
    check("R8 reset state", 5'd0, 3'd0);
    pulse_vd();
    check("R8 nothing pending after reset", 5'd0, 3'd0);
  endtask

  task automatic t_basic();
    put_write(2'b10, mk_word(3'd3, 5'd5, 5'd9, 5'd17, 5'd1, 5'd1, 5'd1, 5'd1), 1'b0);
    check("R3 write not applied before VD", 5'd0, 3'd0);
    pulse_vd(); check("R4 first selector on apply", 5'd5, 3'd0);
    pulse_vd(); check("R5 second selector", 5'd9, 3'd1);
    pulse_vd(); check("R5 third selector", 5'd17, 3'd2);
    pulse_vd(); check("R6 wrap to first", 5'd5, 3'd0);
  endtask

  task automatic t_full();
    put_write(2'b10, mk_word(3'd7, 5'd1, 5'd2, 5'd3, 5'd4, 5'd30, 5'd6, 5'd31), 1'b0);
    for (int k = 0; k < 7; k++) begin
      pulse_vd();
      check("R2 selector layout, count 7",
            (k == 4) ? 5'd30 : (k == 6) ? 5'd31 : 5'(k + 1), 3'(k));
    end
    pulse_vd(); check("R6 wrap after seven", 5'd1, 3'd0);
  endtask

  task automatic t_idle();
    pulse_vd();
    repeat (6) @(negedge clk);
    check("R10 hold without VD", 5'd2, 3'd1);
  endtask

  task automatic t_zero_cnt();
    put_write(2'b10, mk_word(3'd0, 5'd20, 5'd21, 5'd22, 5'd0, 5'd0, 5'd0, 5'd0), 1'b0);
    pulse_vd(); check("R7 count 0 first", 5'd20, 3'd0);
    pulse_vd(); check("R7 count 0 stays", 5'd20, 3'd0);
  endtask

  task automatic t_bad_addr();
    put_write(2'b11, mk_word(3'd2, 5'd3, 5'd4, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0), 1'b0);
    put_write(2'b01, mk_word(3'd2, 5'd7, 5'd8, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0), 1'b0);
    pulse_vd(); check("R1 other address ignored", 5'd20, 3'd0);
  endtask

  task automatic t_last_wins();
    put_write(2'b10, mk_word(3'd2, 5'd10, 5'd11, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0), 1'b0);
    put_write(2'b10, mk_word(3'd2, 5'd12, 5'd13, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0), 1'b0);
    pulse_vd(); check("R9 last write wins", 5'd12, 3'd0);
    pulse_vd(); check("R9 last write second entry", 5'd13, 3'd1);
  endtask

  task automatic t_coincide();
    put_write(2'b10, mk_word(3'd1, 5'd25, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0), 1'b0);
    put_write(2'b10, mk_word(3'd1, 5'd26, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0), 1'b1);
    check("R9 older pending applied on coincident VD", 5'd25, 3'd0);
    pulse_vd(); check("R9 coincident write applied next VD", 5'd26, 3'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_full();
    t_idle();
    t_zero_cnt();
    t_bad_addr();
    t_last_wins();
    t_coincide();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule